// File: doc/BRIEF.md
# Line-Triggered Framebuffer Scanout Controller

This block streams one line at a time out of an external 256 x 256 byte framebuffer SRAM toward a video encoder. An external sync separator supplies a line-start pulse and two sync-status bits. The line-start pulse rises when horizontal sync ends and blanking begins. After each accepted line-start rise, the block waits a fixed number of clocks for blanking to pass. It then samples the two status bits and decides how to treat the line.

On an active-video line, the block walks the pixel byte of the SRAM address through all 256 columns. Each column is held for a fixed number of clocks. The byte read from the SRAM is registered and presented unchanged, so an RRRGGGBB colour byte reaches the encoder exactly as stored. The row byte of the address advances once, when the line is finished. Drawing stops once the row byte reaches a configured limit.

On the first vertical-sync line of a field, the block rewinds the row byte to zero and raises a vertical-sync indication for other logic. Further vertical-sync lines leave everything as it is until the next active-video line clears the indication.

Top module: `scanout_ctrl`

## Requirements
- R1: Only a rising edge of `line_start` seen while the block is idle starts a line. The status inputs are sampled `BLANK_WAIT` clocks after that edge, and the first pixel cycle begins on the clock edge that ends the wait.
- R2: The status code is decoded as follows. `sync_a`=1 with `sync_b`=1 means active video. `sync_a`=1 with `sync_b`=0 means vertical sync. Any code with `sync_a`=0 leaves the address and `vsync_active` unchanged.
- R3: On a drawn line, `sram_addr[7:0]` steps from 0 through 255 in steps of one. Each value is held for `PIX_HOLD` clocks. `pixel_out` shows the byte read at an address one clock after that address is driven.
- R4: `sram_addr[15:8]` increments by one only at the end of a drawn line, and at that moment `sram_addr[7:0]` returns to 0.
- R5: An active-video line whose row byte is already `LINE_STOP` or above draws nothing and leaves `sram_addr` unchanged.
- R6: The first vertical-sync line after an active-video line sets `sram_addr` to 0 and sets `vsync_active`. Later vertical-sync lines change neither. An active-video line clears `vsync_active`, whether or not it draws.
- R7: `pixel_out` is 0x00 during the blanking wait, on lines that are not drawn, and from the second clock after the last pixel's hold ends.
- R8: Pixel bytes reach `pixel_out` unchanged, with no reordering of the RRRGGGBB bits.
- R9: A `line_start` rise that arrives while a line is being drawn is ignored, and the line completes normally.
- R10: After reset, `sram_addr` is 0, `pixel_out` is 0x00 and `vsync_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Line event; a rising edge marks the start of blanking |
| sync_a | input | 1 | First sync-status bit from the separator |
| sync_b | input | 1 | Second sync-status bit from the separator |
| sram_data | input | 8 | Byte read from the framebuffer at `sram_addr` |
| sram_addr | output | 16 | Framebuffer address: row byte in [15:8], column byte in [7:0] |
| pixel_out | output | 8 | Pixel byte to the encoder, RRRGGGBB |
| vsync_active | output | 1 | High from the first vertical-sync line until the next active line |

## Verification
The hardest conditions to reach are the row-limit boundary and the repeated vertical-sync lines. Reaching the limit normally takes a whole field of 768-clock lines. The bench therefore builds the block with a small row limit and a short blanking wait, and sweeps every row up to and past the limit, checking every pixel clock of each row. Vertical-sync lines are sent back to back, so the second line must leave the rewound address and the flag as they are. A line-start pulse is injected in the middle of a drawn line; the pixel stream must continue without a break, and the following line must start on time.

// File: rtl/scanout_ctrl.sv
module scanout_ctrl #(
  parameter int BLANK_WAIT = 75,
  parameter int PIX_HOLD   = 3,
  parameter int LINE_STOP  = 234
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_start,
  input  logic        sync_a,
  input  logic        sync_b,
  input  logic [7:0]  sram_data,
  output logic [15:0] sram_addr,
  output logic [7:0]  pixel_out,
  output logic        vsync_active
);

  localparam int WAIT_W = $clog2(BLANK_WAIT + 1);
  localparam int HOLD_W = $clog2(PIX_HOLD + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DRAW} state_t;

  state_t             state;
  logic               ls_q;
  logic [WAIT_W-1:0]  wait_cnt;
  logic [HOLD_W-1:0]  hold_cnt;
  logic [7:0]         row_q;
  logic [7:0]         col_q;
  logic [7:0]         pix_q;
  logic               vs_done;

  wire line_rise  = line_start && !ls_q;
  wire wait_end   = wait_cnt == WAIT_W'(BLANK_WAIT - 1);
  wire hold_end   = hold_cnt == HOLD_W'(PIX_HOLD - 1);
  wire code_video = sync_a && sync_b;
  wire code_vsync = sync_a && !sync_b;

  assign sram_addr    = {row_q, col_q};
  assign pixel_out    = pix_q;
  assign vsync_active = vs_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ls_q     <= 1'b0;
      wait_cnt <= '0;
      hold_cnt <= '0;
      row_q    <= 8'h00;
      col_q    <= 8'h00;
      pix_q    <= 8'h00;
      vs_done  <= 1'b0;
    end else begin
      ls_q  <= line_start;
      pix_q <= (state == S_DRAW) ? sram_data : 8'h00;
      case (state)
        S_IDLE: begin
          if (line_rise) begin
            state    <= S_WAIT;
            wait_cnt <= '0;
          end
        end
        S_WAIT: begin
          if (wait_end) begin
            state <= S_IDLE;
            if (code_video) begin
              vs_done <= 1'b0;
              if (row_q < 8'(LINE_STOP)) begin
                state    <= S_DRAW;
                col_q    <= 8'h00;
                hold_cnt <= '0;
              end
            end else if (code_vsync && !vs_done) begin
              vs_done <= 1'b1;
              row_q   <= 8'h00;
              col_q   <= 8'h00;
            end
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        S_DRAW: begin
          if (hold_end) begin
            hold_cnt <= '0;
            col_q    <= col_q + 8'h01;
            if (col_q == 8'hFF) begin
              state <= S_IDLE;
              row_q <= row_q + 8'h01;
            end
          end else begin
            hold_cnt <= hold_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scanout_ctrl_chk.sv
module scanout_ctrl_chk #(
  parameter int LINE_STOP = 234
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] sram_addr,
  input logic [7:0]  pixel_out,
  input logic        vsync_active
);

  wire [7:0] col = sram_addr[7:0];
  wire [7:0] row = sram_addr[15:8];

  assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col != $past(col)) |-> (col == $past(col) + 8'h01));

  assert_col_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (col != $past(col)) |-> ($past(col, 1) == $past(col, 2) && $past(col, 2) == $past(col, 3)));

  assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (row != $past(row)) |-> (row == $past(row) + 8'h01 || row == 8'h00));

  assert_row_wrap_col_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (row == $past(row) + 8'h01) |-> (col == 8'h00 && $past(col) == 8'hFF));

  assert_row_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row <= 8'(LINE_STOP));

  assert_quiet_vsync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pixel_out != 8'h00) |-> !vsync_active);

endmodule

bind scanout_ctrl scanout_ctrl_chk #(.LINE_STOP(LINE_STOP)) chk_i (
  .clk(clk), .rst_n(rst_n), .sram_addr(sram_addr),
  .pixel_out(pixel_out), .vsync_active(vsync_active)
);

// File: tb/scanout_ctrl_tb_top.sv
module scanout_ctrl_tb_top;
  localparam int BW   = 10;
  localparam int HOLD = 3;
  localparam int STOP = 6;

  logic clk = 1'b0, rst_n = 1'b0, line_start = 1'b0, sync_a = 1'b0, sync_b = 1'b0;
  logic [7:0] sram_data;
  logic [15:0] sram_addr;
  logic [7:0] pixel_out;
  logic vsync_active;
  int checks = 0, errors = 0;
  int exp_row = 0;
  bit exp_vs = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    logic [7:0] t;
    t = a[15:8] * 8'd37;
    return t ^ a[7:0];
  endfunction

  assign sram_data = mem_f(sram_addr);

  scanout_ctrl #(.BLANK_WAIT(BW), .PIX_HOLD(HOLD), .LINE_STOP(STOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .sync_a(sync_a), .sync_b(sync_b),
    .sram_data(sram_data), .sram_addr(sram_addr), .pixel_out(pixel_out),
    .vsync_active(vsync_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_line(input bit a, input bit b, input bit inject);
    bit draw;
    draw = 1'b0;
    @(negedge clk);
    sync_a = a; sync_b = b; line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    if (a && b) begin
      exp_vs = 1'b0;
      draw = (exp_row < STOP);
    end else if (a && !b && !exp_vs) begin
      exp_vs = 1'b1;
      exp_row = 0;
    end
    if (draw) begin
      for (int n = 0; n < BW; n++) begin
        chk("R7 wait pixel", pixel_out, 0);
        chk("R1 wait addr", sram_addr, exp_row << 8);
        @(negedge clk);
      end
      for (int j = 0; j <= 769; j++) begin
        if (j >= 1 && j <= 768)
          chk("R3/R8 pixel", pixel_out, mem_f(16'((exp_row << 8) + (j - 1) / HOLD)));
        else
          chk("R7 edge pixel", pixel_out, 0);
        if (j <= 767) chk("R3 addr", sram_addr, (exp_row << 8) + j / HOLD);
        else          chk("R4 addr", sram_addr, (exp_row + 1) << 8);
        if (inject && j == 300) line_start = 1'b1;
        if (inject && j == 302) line_start = 1'b0;
        @(negedge clk);
      end
      exp_row++;
      if (inject) chk("R9 idle after", pixel_out, 0);
    end else begin
      for (int n = 0; n < BW + 4; n++) begin
        chk("R7 quiet pixel", pixel_out, 0);
        @(negedge clk);
      end
      chk("R5/R6 addr", sram_addr, exp_row << 8);
    end
    chk("R2/R6 vsync", vsync_active, exp_vs);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 addr", sram_addr, 0);
    chk("R10 pixel", pixel_out, 0);
    chk("R10 vsync", vsync_active, 0);
    run_line(1'b0, 1'b0, 1'b0);
    run_line(1'b1, 1'b1, 1'b0);
    run_line(1'b1, 1'b1, 1'b0);
    run_line(1'b1, 1'b0, 1'b0);
    run_line(1'b1, 1'b0, 1'b0);
    run_line(1'b0, 1'b1, 1'b0);
    for (int r = 0; r < STOP; r++) run_line(1'b1, 1'b1, r == 2);
    run_line(1'b1, 1'b1, 1'b0);
    run_line(1'b1, 1'b1, 1'b0);
    run_line(1'b1, 1'b0, 1'b0);
    run_line(1'b1, 1'b1, 1'b0);
    run_line(1'b0, 1'b1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule